// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the A and B channels of an incremental quadrature encoder into a signed two's-complement position count. Counting resolution is selectable. At the finest setting every edge on either channel moves the count. At the middle setting only A edges move it. At the coarsest setting the count moves once per full electrical cycle. A fourth mode does not decode a quadrature pair at all: a rising edge on A counts up and a rising edge on B counts down.

The index channel Z can preset the count. When reloading is enabled, the count is forced to a programmed value whenever Z is high and the A/B pair sits in a chosen phase state. Counting then carries on from that value. All three encoder lines pass through a two-flop synchronizer before any edge is detected.

In a quadrature mode, a sample in which A and B both change cannot be decoded. Such a sample raises a sticky error flag and leaves the count untouched. The position, direction and error outputs are plain registered levels that can be read in any cycle, so the block has no handshake.

Top module: `qdec_position`

## Requirements
- R1: After reset, `position_o` is 0, `dir_up_o` is 0 and `bad_seq_o` is 0.
- R2: With `mode_i`=0 (single resolution), the count changes once per cycle. It goes +1 when {A,B} moves 00→10 and -1 when {A,B} moves 10→00. No other transition changes it.
- R3: With `mode_i`=1 (double resolution), every A edge changes the count by one. B edges leave it unchanged, so a full cycle gives ±2.
- R4: With `mode_i`=2 (quadruple resolution), every edge of A or B changes the count by one, so a full cycle gives ±4.
- R5: In modes 0 to 2, the {A,B} sequence 00→10→11→01→00 (A leading) counts up and the reverse order counts down. `dir_up_o` becomes 1 after an up count and 0 after a down count, and holds its value when there is no net count.
- R6: With `mode_i`=3 (two-pulse), a rising edge on A gives +1 and a rising edge on B gives -1. Falling edges do nothing, and simultaneous rising edges leave the count and `dir_up_o` unchanged.
- R7: The count loads `zrl_value_i` in any cycle where `zrl_en_i` is 1, synchronized Z is 1 and synchronized {A,B} equals `zrl_phase_i` (bit 1 = A, bit 0 = B). Z has no effect when the phase differs or when `zrl_en_i` is 0.
- R8: When a reload and a count step fall in the same cycle, the loaded value wins.
- R9: After a reload, later steps count from the loaded value.
- R10: In modes 0 to 2, a sample in which A and B both change leaves the count unchanged and sets `bad_seq_o`. The flag stays set until reset.
- R11: The count wraps modulo 2^32: +1 from 0x7FFFFFFF gives 0x80000000, and -1 from 0x80000000 gives 0x7FFFFFFF.
- R12: A change on the encoder inputs shows at the outputs three clock edges after the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Encoder channel A (asynchronous) |
| enc_b_i | input | 1 | Encoder channel B (asynchronous) |
| enc_z_i | input | 1 | Encoder index channel (asynchronous) |
| mode_i | input | 2 | 0 single, 1 double, 2 quadruple, 3 two-pulse |
| zrl_en_i | input | 1 | Enables reload from the index channel |
| zrl_phase_i | input | 2 | {A,B} state in which Z triggers a reload |
| zrl_value_i | input | 32 | Value loaded on reload |
| position_o | output | 32 | Signed position count |
| dir_up_o | output | 1 | Direction of the last net count (1 = up) |
| bad_seq_o | output | 1 | Sticky flag for undecodable A/B transitions |

## Verification
The two functions that can meet in one cycle are an index reload and a decoded count step. The bench provokes this by raising Z in the same sample in which A moves into the programmed reload phase. The expected position is then the reload value, with no +1 applied, and the step's direction still shows on `dir_up_o`. The next steps are checked to count on from that value. The bench also drives Z at a wrong phase and with reload disabled, to show that only the full condition loads the count.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    QM_X1    = 2'd0,
    QM_X2    = 2'd1,
    QM_X4    = 2'd2,
    QM_PULSE = 2'd3
  } qmode_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  qmode_e     mode_i,
  input  logic [1:0] ab_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       bad_o
);
  logic [1:0] prev_q;
  logic       a_chg, b_chg, fwd, rev, one_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ab_i;
  end

  always_comb begin
    a_chg   = ab_i[1] ^ prev_q[1];
    b_chg   = ab_i[0] ^ prev_q[0];
    one_chg = a_chg ^ b_chg;
    // A leading: new A is old B inverted, new B is old A
    fwd     = one_chg && (ab_i[1] == ~prev_q[0]) && (ab_i[0] == prev_q[1]);
    rev     = one_chg && (ab_i[1] == prev_q[0]) && (ab_i[0] == ~prev_q[1]);
    up_o    = 1'b0;
    dn_o    = 1'b0;
    bad_o   = 1'b0;
    unique case (mode_i)
      QM_X4: begin
        up_o  = fwd;
        dn_o  = rev;
        bad_o = a_chg && b_chg;
      end
      QM_X2: begin
        up_o  = fwd && a_chg;
        dn_o  = rev && a_chg;
        bad_o = a_chg && b_chg;
      end
      QM_X1: begin
        up_o  = a_chg && !b_chg && !ab_i[0] && ab_i[1];
        dn_o  = a_chg && !b_chg && !ab_i[0] && !ab_i[1];
        bad_o = a_chg && b_chg;
      end
      QM_PULSE: begin
        up_o  = ab_i[1] && !prev_q[1];
        dn_o  = ab_i[0] && !prev_q[0];
      end
      default: ;
    endcase
  end

  p_bad_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_o |-> (!up_o && !dn_o));
  p_quad_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != QM_PULSE) |-> !(up_o && dn_o));
endmodule

// File: rtl/qdec_accum.sv
module qdec_accum #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             bad_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             dir_o,
  output logic             err_o
);
  logic [CNT_W-1:0] pos_q;
  logic             dir_q, err_q;
  logic             net_up, net_dn;

  assign net_up = up_i && !dn_i;
  assign net_dn = dn_i && !up_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (load_i)      pos_q <= load_val_i;
      else if (net_up) pos_q <= pos_q + CNT_W'(1);
      else if (net_dn) pos_q <= pos_q - CNT_W'(1);
      if (net_up)      dir_q <= 1'b1;
      else if (net_dn) dir_q <= 1'b0;
      if (bad_i)       err_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;
  assign dir_o = dir_q;
  assign err_o = err_q;

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pos_q == $past(load_val_i)));
  p_hold_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !net_up && !net_dn) |=> $stable(pos_q));
  p_up_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && net_up) |=> (pos_q == $past(pos_q) + CNT_W'(1)));
  p_dn_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && net_dn) |=> (pos_q == $past(pos_q) - CNT_W'(1)));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/qdec_position.sv
module qdec_position
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             enc_z_i,
  input  logic [1:0]       mode_i,
  input  logic             zrl_en_i,
  input  logic [1:0]       zrl_phase_i,
  input  logic [CNT_W-1:0] zrl_value_i,
  output logic [CNT_W-1:0] position_o,
  output logic             dir_up_o,
  output logic             bad_seq_o
);
  localparam int NCH = 3;

  logic [NCH-1:0] sync_abz;
  logic [1:0]     ab_s;
  logic           z_s;
  logic           step_up, step_dn, step_bad, reload;
  qmode_e         mode;

  assign mode = qmode_e'(mode_i);

  qdec_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({enc_a_i, enc_b_i, enc_z_i}),
    .sync_o  (sync_abz)
  );

  assign ab_s = sync_abz[2:1];
  assign z_s  = sync_abz[0];

  qdec_step u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .ab_i   (ab_s),
    .up_o   (step_up),
    .dn_o   (step_dn),
    .bad_o  (step_bad)
  );

  assign reload = zrl_en_i && z_s && (ab_s == zrl_phase_i);

  qdec_accum #(.CNT_W(CNT_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_i       (step_up),
    .dn_i       (step_dn),
    .bad_i      (step_bad),
    .load_i     (reload),
    .load_val_i (zrl_value_i),
    .pos_o      (position_o),
    .dir_o      (dir_up_o),
    .err_o      (bad_seq_o)
  );

  p_no_reload_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!zrl_en_i && !step_up && !step_dn) |=> $stable(position_o));
endmodule

// File: tb/qdec_position_tb.sv
module qdec_position_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        zrl_en = 1'b0;
  logic [1:0]  zrl_phase = 2'b00;
  logic [31:0] zrl_value = '0;
  logic [31:0] position;
  logic        dir_up, bad_seq;

  always #10 clk = ~clk;

  qdec_position u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_a_i     (enc_a),
    .enc_b_i     (enc_b),
    .enc_z_i     (enc_z),
    .mode_i      (mode),
    .zrl_en_i    (zrl_en),
    .zrl_phase_i (zrl_phase),
    .zrl_value_i (zrl_value),
    .position_o  (position),
    .dir_up_o    (dir_up),
    .bad_seq_o   (bad_seq)
  );

  typedef struct {
    logic [31:0] pos;
    logic        dir;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          tests = 0, fails = 0;
  logic [31:0] e_pos = '0;
  logic        e_dir = 1'b0, e_err = 1'b0;
  bit          done = 1'b0;

  // monitor: compares each queued expectation at a falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        tests++;
        if (position !== it.pos || dir_up !== it.dir || bad_seq !== it.err) begin
          fails++;
          $display("FAIL %s: pos=%h dir=%b err=%b expected pos=%h dir=%b err=%b",
                   it.tag, position, dir_up, bad_seq, it.pos, it.dir, it.err);
        end
      end
    end
  end

  // driver: applies one input sample, waits the R12 latency, queues the expectation
  task automatic apply(input logic a, input logic b, input logic z, input int delta,
                       input bit ld, input logic [31:0] ldv, input bit inv,
                       input string tag);
    @(negedge clk);
    enc_a = a; enc_b = b; enc_z = z;
    repeat (4) @(posedge clk);
    if (delta > 0)      e_dir = 1'b1;
    else if (delta < 0) e_dir = 1'b0;
    if (ld) e_pos = ldv;
    else    e_pos = e_pos + 32'(delta);
    if (inv) e_err = 1'b1;
    sb_q.push_back('{e_pos, e_dir, e_err, tag});
    wait (sb_q.size() == 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    sb_q.push_back('{32'd0, 1'b0, 1'b0, "R1 reset"});
    wait (sb_q.size() == 0);

    // R4 / R5 quadruple, forward then reverse
    set_mode(2'd2);
    apply(1,0,0, 1,0,0,0,"R4 x4 fwd 00-10");
    apply(1,1,0, 1,0,0,0,"R4 x4 fwd 10-11");
    apply(0,1,0, 1,0,0,0,"R4 x4 fwd 11-01");
    apply(0,0,0, 1,0,0,0,"R5 x4 fwd 01-00");
    apply(0,1,0,-1,0,0,0,"R5 x4 rev 00-01");
    apply(1,1,0,-1,0,0,0,"R4 x4 rev 01-11");
    apply(1,0,0,-1,0,0,0,"R4 x4 rev 11-10");
    apply(0,0,0,-1,0,0,0,"R4 x4 rev 10-00");

    // R3 double
    set_mode(2'd1);
    apply(1,0,0, 1,0,0,0,"R3 x2 A rise");
    apply(1,1,0, 0,0,0,0,"R3 x2 B edge ignored");
    apply(0,1,0, 1,0,0,0,"R3 x2 A fall");
    apply(0,0,0, 0,0,0,0,"R3 x2 B edge ignored");
    apply(0,1,0, 0,0,0,0,"R3 x2 rev B edge");
    apply(1,1,0,-1,0,0,0,"R3 x2 rev A rise");
    apply(1,0,0, 0,0,0,0,"R3 x2 rev B edge");
    apply(0,0,0,-1,0,0,0,"R3 x2 rev A fall");

    // R2 single
    set_mode(2'd0);
    apply(1,0,0, 1,0,0,0,"R2 x1 count on 00-10");
    apply(1,1,0, 0,0,0,0,"R2 x1 no count");
    apply(0,1,0, 0,0,0,0,"R2 x1 no count");
    apply(0,0,0, 0,0,0,0,"R2 x1 no count");
    apply(0,1,0, 0,0,0,0,"R2 x1 rev no count");
    apply(1,1,0, 0,0,0,0,"R2 x1 rev no count");
    apply(1,0,0, 0,0,0,0,"R2 x1 rev no count");
    apply(0,0,0,-1,0,0,0,"R2 x1 rev count on 10-00");

    // R6 two-pulse
    set_mode(2'd3);
    apply(1,0,0, 1,0,0,0,"R6 A rise up");
    apply(0,0,0, 0,0,0,0,"R6 A fall ignored");
    apply(0,1,0,-1,0,0,0,"R6 B rise down");
    apply(0,0,0, 0,0,0,0,"R6 B fall ignored");
    apply(1,1,0, 0,0,0,0,"R6 both rise cancel");
    apply(0,0,0, 0,0,0,0,"R6 both fall ignored");

    // R7 / R8 / R9 index reload in quadruple mode, phase {A,B}=10
    set_mode(2'd2);
    @(negedge clk);
    zrl_en = 1'b1; zrl_phase = 2'b10; zrl_value = 32'd100;
    apply(1,0,1, 1,1,32'd100,0,"R8 reload beats step");
    apply(1,1,0, 1,0,0,0,"R9 count on after reload");
    apply(0,1,0, 1,0,0,0,"R9 count on");
    apply(0,0,1, 1,0,0,0,"R7 Z at wrong phase");
    apply(0,0,0, 0,0,0,0,"R7 Z drop");
    @(negedge clk) zrl_en = 1'b0;
    apply(1,0,1, 1,0,0,0,"R7 reload disabled");
    apply(1,1,0, 1,0,0,0,"R7 count after disabled Z");
    apply(0,1,0, 1,0,0,0,"R4 count");
    apply(0,0,0, 1,0,0,0,"R4 count");

    // R11 wrap
    @(negedge clk);
    zrl_en = 1'b1; zrl_phase = 2'b00; zrl_value = 32'h7FFF_FFFF;
    apply(0,0,1, 0,1,32'h7FFF_FFFF,0,"R7 reload at matching phase");
    apply(0,0,0, 0,0,0,0,"R7 hold after Z drop");
    @(negedge clk) zrl_en = 1'b0;
    apply(1,0,0, 1,0,0,0,"R11 wrap up");
    apply(0,0,0,-1,0,0,0,"R11 wrap down");

    // R10 undecodable transitions, sticky flag
    apply(1,1,0, 0,0,0,1,"R10 double change");
    apply(0,0,0, 0,0,0,1,"R10 double change back");
    apply(1,0,0, 1,0,0,0,"R10 flag sticky after valid step");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule